// File: doc/BRIEF.md
# ADC Result Window Comparator

This block sits beside an ADC and examines each conversion result as it arrives on a 16-bit bus with a one-cycle valid strobe. It holds two 16-bit limits, an upper bound ("above" limit) and a lower bound ("below" limit). When a result falls in the selected region, it sets a sticky hit flag. Software can poll that flag or route it out as an interrupt request.

There is no mode bit. The order of the two limits picks the region. If the below limit is larger than the above limit, the region is the band between them. Otherwise the region is everything outside the two limits.

Each limit is loaded one byte at a time through a small byte-wide register port. Writing one byte takes effect immediately, even if the other byte has not been written yet.

Top module: `adc_window_cmp`

## Requirements
- R1: After reset, the above limit is 0xFFFF, the below limit is 0x0000, the hit flag is 0, the interrupt enable is 0 and `win_irq` is 0. With these values no result can set the flag.
- R2: Each limit byte can be written and read back on its own at these addresses:
  - 0: above limit, low byte
  - 1: above limit, high byte
  - 2: below limit, low byte
  - 3: below limit, high byte
- R3: When the below limit is greater than the above limit (a band), a result hits only if it is strictly greater than the above limit and strictly less than the below limit. All comparisons are unsigned.
- R4: When the below limit is less than or equal to the above limit, a result hits if it is strictly less than the below limit or strictly greater than the above limit. All comparisons are unsigned.
- R5: The flag reads back as 1 on the cycle after a hitting result is sampled with `res_valid` high. Data presented while `res_valid` is low never sets the flag.
- R6: Address 4 is the control register. Bit 0 reads as the flag, and bit 1 is the interrupt enable (read/write). Once set, the flag stays set until a write to address 4 with bit 0 = 1. A write to address 4 with bit 0 = 0 leaves the flag unchanged.
- R7: If a hitting valid result and a clearing write land in the same cycle, the flag ends up set.
- R8: `win_irq` is high exactly when both the flag and the interrupt enable are 1.
- R9: Each comparison uses the limit registers as they stood before the clock edge on which the result is sampled:
  - A limit byte written on that same edge is not used for that result.
  - A limit with only one byte rewritten is used as it stands.
- R10: `reg_rdata` is 0 while `reg_re` is low, and is 0 for addresses 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Strobe marking a new conversion result |
| res_data | input | 16 | Conversion result |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable |
| reg_rdata | output | 8 | Register read data (combinational) |
| win_irq | output | 1 | Window interrupt request |

## Verification
The hardest cases to reach are those where two events fall on the same clock edge. In one, a result strobe coincides with a write that clears the flag. In another, it coincides with a write that changes one byte of a limit. The bench drives the strobe and the register write in the same cycle, with values chosen so that the old and new limit give opposite outcomes. It also leaves a limit half-rewritten, so that the band silently turns into an outside region.

// File: rtl/adc_window_cmp.sv
module adc_window_cmp #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [7:0]        reg_rdata,
  output logic              win_irq
);
  localparam logic [ADDR_W-1:0] A_ABV_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ABV_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_BLW_LO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_BLW_HI = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(4);

  logic [7:0] abv_lo, abv_hi, blw_lo, blw_hi;
  logic       hit_flag, irq_en;

  wire [15:0] abv_lim = {abv_hi, abv_lo};
  wire [15:0] blw_lim = {blw_hi, blw_lo};
  wire [15:0] sample  = 16'(res_data);

  wire is_above = sample > abv_lim;
  wire is_below = sample < blw_lim;
  wire band     = blw_lim > abv_lim;
  wire hit_now  = res_valid & (band ? (is_above & is_below) : (is_above | is_below));
  wire clr_req  = reg_we & (reg_addr == A_CTRL) & reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abv_lo <= 8'hFF;
      abv_hi <= 8'hFF;
      blw_lo <= 8'h00;
      blw_hi <= 8'h00;
      irq_en <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_ABV_LO: abv_lo <= reg_wdata;
        A_ABV_HI: abv_hi <= reg_wdata;
        A_BLW_LO: blw_lo <= reg_wdata;
        A_BLW_HI: blw_hi <= reg_wdata;
        A_CTRL:   irq_en <= reg_wdata[1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_flag <= 1'b0;
    else        hit_flag <= hit_now | (hit_flag & ~clr_req);
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_re) begin
      case (reg_addr)
        A_ABV_LO: reg_rdata = abv_lo;
        A_ABV_HI: reg_rdata = abv_hi;
        A_BLW_LO: reg_rdata = blw_lo;
        A_BLW_HI: reg_rdata = blw_hi;
        A_CTRL:   reg_rdata = {6'b0, irq_en, hit_flag};
        default:  reg_rdata = 8'h00;
      endcase
    end
  end

  assign win_irq = hit_flag & irq_en;
endmodule

// File: rtl/adc_window_cmp_chk.sv
module adc_window_cmp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       res_valid,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_we,
  input logic       hit_flag,
  input logic       irq_en,
  input logic       win_irq
);
  wire clr_wr = reg_we && reg_addr == 3'd4 && reg_wdata[0];

  AST_SET_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) $rose(hit_flag) |-> $past(res_valid)); // R5
  AST_IDLE_NO_SET:     assert property (@(posedge clk) disable iff (!rst_n) (!res_valid && !hit_flag) |=> !hit_flag); // R5
  AST_FLAG_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) (hit_flag && !clr_wr) |=> hit_flag); // R6
  AST_CLEAR_WORKS:     assert property (@(posedge clk) disable iff (!rst_n) (clr_wr && !res_valid) |=> !hit_flag); // R6
  AST_IRQ_NEEDS_EN:    assert property (@(posedge clk) disable iff (!rst_n) win_irq |-> (irq_en && hit_flag)); // R8
  AST_IRQ_FOLLOWS:     assert property (@(posedge clk) disable iff (!rst_n) (hit_flag && irq_en) |-> win_irq); // R8
endmodule

bind adc_window_cmp adc_window_cmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_we(reg_we), .hit_flag(hit_flag),
  .irq_en(irq_en), .win_irq(win_irq)
);

// File: tb/adc_window_cmp_tb.sv
`timescale 1ns/100ps
module adc_window_cmp_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_rdata;
  logic win_irq;
  int n_run = 0, n_fail = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  adc_window_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .win_irq(win_irq)
  );

  // {above limit, below limit, result, expected hit}
  localparam int NV = 17;
  localparam logic [48:0] VEC [NV] = '{
    {16'h1000, 16'h2000, 16'h1800, 1'b1}, // R3
    {16'h1000, 16'h2000, 16'h1000, 1'b0}, // R3
    {16'h1000, 16'h2000, 16'h2000, 1'b0}, // R3
    {16'h1000, 16'h2000, 16'h0800, 1'b0}, // R3
    {16'h1000, 16'h2000, 16'h2800, 1'b0}, // R3
    {16'h1000, 16'h2000, 16'h1001, 1'b1}, // R3
    {16'h1000, 16'h2000, 16'h1FFF, 1'b1}, // R3
    {16'h3000, 16'h1000, 16'h0FFF, 1'b1}, // R4
    {16'h3000, 16'h1000, 16'h1000, 1'b0}, // R4
    {16'h3000, 16'h1000, 16'h3000, 1'b0}, // R4
    {16'h3000, 16'h1000, 16'h3001, 1'b1}, // R4
    {16'h3000, 16'h1000, 16'h2000, 1'b0}, // R4
    {16'h5000, 16'h5000, 16'h5000, 1'b0}, // R4
    {16'h5000, 16'h5000, 16'h4FFF, 1'b1}, // R4
    {16'h5000, 16'h5000, 16'h5001, 1'b1}, // R4
    {16'hFFFF, 16'h0000, 16'hFFFF, 1'b0}, // R1
    {16'hFFFF, 16'h0000, 16'h0000, 1'b0}  // R1
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    reg_re = 1'b0;
  endtask

  task automatic set_limits(input logic [15:0] abv, input logic [15:0] blw);
    wr(3'd0, abv[7:0]); wr(3'd1, abv[15:8]);
    wr(3'd2, blw[7:0]); wr(3'd3, blw[15:8]);
  endtask

  task automatic sample(input logic [15:0] d);
    @(negedge clk); res_data = d; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0, rv); check("R1 above lo", rv, 8'hFF);
    rd(3'd1, rv); check("R1 above hi", rv, 8'hFF);
    rd(3'd2, rv); check("R1 below lo", rv, 8'h00);
    rd(3'd3, rv); check("R1 below hi", rv, 8'h00);
    rd(3'd4, rv); check("R1 ctrl", rv, 8'h00);
    check("R1 irq", win_irq, 1'b0);

    wr(3'd0, 8'h5A); wr(3'd3, 8'hC3);
    rd(3'd0, rv); check("R2 above lo", rv, 8'h5A);
    rd(3'd1, rv); check("R2 above hi untouched", rv, 8'hFF);
    rd(3'd2, rv); check("R2 below lo untouched", rv, 8'h00);
    rd(3'd3, rv); check("R2 below hi", rv, 8'hC3);

    for (int i = 0; i < NV; i++) begin
      set_limits(VEC[i][48:33], VEC[i][32:17]);
      wr(3'd4, 8'h01);
      sample(VEC[i][16:1]);
      rd(3'd4, rv);
      check($sformatf("R3/R4 vector %0d", i), rv[0], VEC[i][0]);
    end

    // R5: hitting data without strobe
    set_limits(16'h1000, 16'h2000); wr(3'd4, 8'h01);
    @(negedge clk); res_data = 16'h1800; res_valid = 1'b0;
    @(negedge clk); #1 rd(3'd4, rv); check("R5 no strobe", rv[0], 1'b0);
    // R5: flag visible the cycle after the strobe
    @(negedge clk); res_data = 16'h1800; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0; reg_addr = 3'd4; reg_re = 1'b1;
    #1 check("R5 next cycle", reg_rdata[0], 1'b1); reg_re = 1'b0;
    // R6 sticky
    sample(16'h0100); rd(3'd4, rv); check("R6 sticky after miss", rv[0], 1'b1);
    wr(3'd4, 8'h00); rd(3'd4, rv); check("R6 write 0 keeps", rv[0], 1'b1);
    wr(3'd4, 8'h01); rd(3'd4, rv); check("R6 clear", rv[0], 1'b0);
    // R7 set wins
    @(negedge clk); res_data = 16'h1800; res_valid = 1'b1;
    reg_addr = 3'd4; reg_wdata = 8'h01; reg_we = 1'b1;
    @(negedge clk); res_valid = 1'b0; reg_we = 1'b0;
    rd(3'd4, rv); check("R7 set wins", rv[0], 1'b1);
    // R8 interrupt
    check("R8 irq disabled", win_irq, 1'b0);
    wr(3'd4, 8'h02); #1 check("R8 irq enabled", win_irq, 1'b1);
    rd(3'd4, rv); check("R8 ctrl readback", rv, 8'h03);
    wr(3'd4, 8'h03); #1 check("R8 irq after clear", win_irq, 1'b0);
    wr(3'd4, 8'h00);
    // R9 same-edge write uses old limit
    @(negedge clk); res_data = 16'h1005; res_valid = 1'b1;
    reg_addr = 3'd0; reg_wdata = 8'h10; reg_we = 1'b1;
    @(negedge clk); res_valid = 1'b0; reg_we = 1'b0;
    rd(3'd4, rv); check("R9 old limit used", rv[0], 1'b1);
    wr(3'd4, 8'h01);
    sample(16'h1005); rd(3'd4, rv); check("R9 new limit used", rv[0], 1'b0);
    // R9 half update: below becomes 0x0000 -> outside region
    wr(3'd0, 8'h00); wr(3'd3, 8'h00);
    sample(16'h0800); rd(3'd4, rv); check("R9 half-updated limit", rv[0], 1'b0);
    sample(16'h1001); rd(3'd4, rv); check("R9 half-updated above", rv[0], 1'b1);
    // R10
    @(negedge clk); reg_addr = 3'd4; reg_re = 1'b0;
    #1 check("R10 re low", reg_rdata, 8'h00);
    rd(3'd5, rv); check("R10 addr 5", rv, 8'h00);
    rd(3'd7, rv); check("R10 addr 7", rv, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule